// File: doc/BRIEF.md
# Compressed Multi-Channel Pulse Delay

This block delays a group of parallel one-bit pulse channels by a programmable number of enabled clock cycles. It does not use one long shift register per channel. An encoder watches the whole channel vector and records each stretch of constant value as a single entry: the vector itself and how many cycles it lasted. The entries go into a small inferred FIFO. A decoder replays them once the programmed delay has elapsed. Storage therefore grows with the number of transitions inside the delay window, not with the window's length.

All channels share one encoder, one FIFO and one decoder. Several channels that switch on the same cycle produce a single record with several bits changed, and they come out together on one registered edge. A run longer than the run counter can hold is split into consecutive records that carry the same vector. The programmed delay must be at least 2^RUNW cycles, so that a run's record exists before the decoder needs it. The FIFO must hold every record that is in flight during the delay. Two sticky flags report an encoder record dropped on a full FIFO and a decoder read from an empty FIFO.

Top module: `rle_pulse_delay`

## Requirements
- R1: While rst_n is low and right after its release, dout is all zeros and ovf and unf are 0.
- R2: Let k be the count of enabled cycles since reset, starting at 0. After the k-th enabled clock edge, dout equals the din vector sampled at enabled edge k-D, where D is the value of `delay`. dout stays all zeros until k reaches D.
- R3: If the encoder must store a record while the FIFO holds DEPTH records and no record is read in the same cycle, the record is dropped and ovf goes to 1.
- R4: If the decoder needs a record while the FIFO is empty, unf goes to 1. This happens, for example, when D is below 2^RUNW and the input holds its value longer than D cycles.
- R5: A constant input held longer than 2^RUNW-1 cycles comes out with its full length. It is carried as several records, each no longer than 2^RUNW-1 cycles.
- R6: Changes on several channels in the same input cycle appear on dout on the same clock edge, for example 4'b0010 followed directly by 4'b0101.
- R7: While en is low, no input is sampled, the delay does not advance and dout holds its value. The delay counts enabled cycles only.
- R8: R2 holds at the smallest legal delay, D = 2^RUNW.
- R9: Once set, ovf and unf stay at 1 until rst_n goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sample and replay enable |
| din | input | NCH | Input channel vector |
| delay | input | DLYW | Delay in enabled cycles, held static while running |
| dout | output | NCH | Delayed channel vector, registered |
| ovf | output | 1 | Sticky FIFO overflow |
| unf | output | 1 | Sticky FIFO underflow |

## Verification
A queue-based shift-register model checks dout on every cycle. Several stimulus shapes are used:
- Single-cycle toggling catches a decoder that loses or repeats cycles when records are one cycle long.
- A 40-cycle constant run catches a run counter that wraps without writing a split record, which would shorten the pulse.
- A multi-bit change catches per-channel skew.
- An enable gap catches a decoder that keeps draining while the encoder is stalled, which would shift everything after the gap.

Separate runs cover the rest:
- The minimum delay exposes an off-by-one in the start comparison.
- A too-short delay must raise underflow.
- A long delay with dense toggling must raise overflow.
- Both flags must stay set through idle cycles.

// File: rtl/rle_pulse_delay.sv
module rle_pulse_delay #(
  parameter int NCH   = 4,
  parameter int RUNW  = 4,
  parameter int DEPTH = 32,
  parameter int DLYW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [NCH-1:0]  din,
  input  logic [DLYW-1:0] delay,
  output logic [NCH-1:0]  dout,
  output logic            ovf,
  output logic            unf
);
  localparam int AW   = $clog2(DEPTH);
  localparam int RECW = NCH + RUNW;
  localparam logic [RUNW-1:0] RUN_MAX = '1;
  localparam logic [RUNW-1:0] RUN_ONE = RUNW'(1);
  localparam logic [DLYW-1:0] AGE_ONE = DLYW'(1);
  localparam logic [AW:0]     FULLV   = (AW+1)'(DEPTH);

  logic [RECW-1:0] mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [AW:0]     fill;
  logic            started, playing;
  logic [NCH-1:0]  run_st;
  logic [RUNW-1:0] run_len, rem;
  logic [DLYW-1:0] age;
  logic [RECW-1:0] rd_rec;
  logic            full, empty, push, wr, start, pop_want, pop;

  assign full     = (fill == FULLV);
  assign empty    = (fill == '0);
  assign push     = en && started && ((din != run_st) || (run_len == RUN_MAX));
  assign start    = en && started && !playing && (age == delay);
  assign pop_want = start || (en && playing && rem == '0);
  assign pop      = pop_want && !empty;
  assign wr       = push && (!full || pop);
  assign rd_rec   = mem[rd_ptr];

  always_ff @(posedge clk)
    if (wr) mem[wr_ptr] <= {run_st, run_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      playing <= 1'b0;
      run_st  <= '0;
      run_len <= '0;
      rem     <= '0;
      age     <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill    <= '0;
      dout    <= '0;
      ovf     <= 1'b0;
      unf     <= 1'b0;
    end else if (en) begin
      if (!started) begin
        started <= 1'b1;
        run_st  <= din;
        run_len <= RUN_ONE;
        age     <= AGE_ONE;
      end else begin
        if (push) begin
          run_st  <= din;
          run_len <= RUN_ONE;
        end else begin
          run_len <= run_len + 1'b1;
        end
        if (!playing) age <= age + 1'b1;
      end

      if (wr)  wr_ptr <= wr_ptr + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      case ({wr, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase

      if (push && !wr)       ovf <= 1'b1;
      if (pop_want && empty) unf <= 1'b1;
      if (start)             playing <= 1'b1;

      if (pop) begin
        dout <= rd_rec[RECW-1:RUNW];
        rem  <= rd_rec[RUNW-1:0] - 1'b1;
      end else if (playing && rem != '0) begin
        rem <= rem - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rle_pulse_delay_chk.sv
module rle_pulse_delay_chk #(
  parameter int NCH   = 4,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [NCH-1:0] dout,
  input logic           ovf,
  input logic           unf,
  input logic           push,
  input logic           full,
  input logic           empty,
  input logic           pop,
  input logic           pop_want,
  input logic [AW:0]    fill
);
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf);
  assert_ovf_on_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ovf);
  assert_unf_on_starve_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_want && empty) |=> unf);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));
  assert_dout_from_record_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && pop) |=> $stable(dout));
  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH);
endmodule

bind rle_pulse_delay rle_pulse_delay_chk #(.NCH(NCH), .DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .dout(dout), .ovf(ovf), .unf(unf),
  .push(push), .full(full), .empty(empty), .pop(pop), .pop_want(pop_want),
  .fill(fill)
);

// File: tb/rle_pulse_delay_tb_top.sv
module rle_pulse_delay_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] din = '0;
  logic [7:0] dly = 8'd20;
  logic [3:0] dout;
  logic       ovf, unf;

  int         checks = 0;
  int         errors = 0;
  bit         chk_on = 1'b0;
  string      cur_tag = "R2";
  logic [3:0] exp_q[$];
  logic [3:0] exp_v = '0;

  always #(CLK_P/2) clk = ~clk;

  rle_pulse_delay dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .delay(dly),
    .dout(dout), .ovf(ovf), .unf(unf)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input logic [3:0] v, input bit e);
    @(negedge clk);
    din = v;
    en  = e;
    if (e) exp_q.push_back(v);
  endtask

  task automatic hold(input logic [3:0] v, input int n);
    for (int i = 0; i < n; i++) step(v, 1'b1);
  endtask

  task automatic reset_dut(input logic [7:0] d);
    @(negedge clk);
    chk_on = 1'b0;
    rst_n = 1'b0;
    en = 1'b0;
    din = '0;
    dly = d;
    exp_q.delete();
    exp_v = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dout == 4'h0, "R1 dout", dout, 0);
    check(ovf == 1'b0, "R1 ovf", ovf, 0);
    check(unf == 1'b0, "R1 unf", unf, 0);
  endtask

  // monitor: reference shift-register model fed by the driver's queue
  always @(posedge clk) begin
    #3;
    if (rst_n && chk_on) begin
      if (en && exp_q.size() > int'(dly)) exp_v = exp_q.pop_front();
      check(dout == exp_v, cur_tag, dout, exp_v);
    end
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Main stream: D = 20
    reset_dut(8'd20);
    chk_on = 1'b1;
    cur_tag = "R2 mixed";
    hold(4'b0000, 5);
    cur_tag = "R6 coincident edges";
    hold(4'b0010, 3);
    hold(4'b0101, 4);
    cur_tag = "R2 single-cycle toggles";
    for (int i = 0; i < 10; i++) begin
      step(4'b1111, 1'b1);
      step(4'b0000, 1'b1);
    end
    cur_tag = "R5 long run";
    hold(4'b1000, 40);
    cur_tag = "R7 enable gap";
    for (int i = 0; i < 6; i++) step(4'b0110, 1'b0);
    hold(4'b0110, 7);
    cur_tag = "R2 flush";
    hold(4'b0000, 30);
    @(negedge clk);
    check(ovf == 1'b0, "R3 no false overflow", ovf, 0);
    check(unf == 1'b0, "R4 no false underflow", unf, 0);

    // Minimum delay: D = 16
    reset_dut(8'd16);
    chk_on = 1'b1;
    cur_tag = "R8 minimum delay";
    hold(4'b1100, 16);
    step(4'b0011, 1'b1);
    hold(4'b1100, 2);
    hold(4'b1001, 33);
    hold(4'b0000, 20);
    @(negedge clk);
    check(unf == 1'b0, "R8 no underflow at minimum delay", unf, 0);

    // Underflow: D = 5 with a 25-cycle constant run
    reset_dut(8'd5);
    hold(4'b1010, 25);
    step(4'b1010, 1'b0);
    check(unf == 1'b1, "R4 underflow", unf, 1);
    check(ovf == 1'b0, "R4 no overflow", ovf, 0);
    for (int i = 0; i < 4; i++) step(4'b0000, 1'b0);
    check(unf == 1'b1, "R9 underflow sticky", unf, 1);

    // Overflow: D = 60 with dense toggling
    reset_dut(8'd60);
    for (int i = 0; i < 30; i++) begin
      step(4'b0001, 1'b1);
      step(4'b0000, 1'b1);
    end
    step(4'b0000, 1'b0);
    check(ovf == 1'b1, "R3 overflow", ovf, 1);
    for (int i = 0; i < 4; i++) step(4'b0000, 1'b0);
    check(ovf == 1'b1, "R9 overflow sticky", ovf, 1);
    reset_dut(8'd20);
    check(ovf == 1'b0, "R9 overflow cleared by reset", ovf, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule